// File: doc/BRIEF.md
# Fetch and Micro-op Program Counter Sequencer

This block holds the sequencing state of a simple in-order core's front end. It keeps three chained program counters: the current, the following and the one after that. It also keeps a pair of micro-op counters and a byte offset for fetching. From this state it produces a word-aligned fetch address.

Once per retired step the block moves the state forward. The surrounding pipeline tells it what happened during the step:
- the decoder needed more bytes,
- a fault was raised,
- a macro-op was decoded,
- the current micro-op was the last one,
- a variable-length instruction was completed.

Fault vector selection, decoding and memory access belong to the surrounding pipeline.

Top module: `pc_sequencer`

## Requirements
- R1: `fetch_addr` always equals `pc` plus the internal fetch offset, with bits [1:0] forced to zero. The offset is zero after reset.
- R2: On a step with no fault while outside a macro-op, `need_more` high keeps `pc`, `npc`, `nnpc` and the micro state unchanged and raises `fetch_addr` by 4. Inside a macro-op, `need_more` is ignored.
- R3: Every step that is not a `need_more` hold clears the fetch offset to zero. This includes fault steps.
- R4: A step with `fault` high sets `upc` to 0, `nupc` to 1 and `in_macro` to 0, and leaves `pc`, `npc` and `nnpc` unchanged.
- R5: A step whose current micro-op has `last_uop` high ends macro-op mode, sets `upc`/`nupc` to 0/1, and advances the PC chain as in R7.
- R6: A step inside a macro-op with `last_uop` low moves `nupc` into `upc`, raises `nupc` by one, and leaves the PC chain unchanged.
- R7: A step outside macro-op mode that completes an instruction does the following: `pc` takes `npc`, `npc` takes `nnpc`, and `nnpc` takes `nnpc`+4.
- R8: When an instruction is decoded outside a macro-op with `len_en` high, the block first replaces the following PC with `pc`+`inst_len`, then applies R6 or R7.
- R9: A decoded instruction with `is_macro` high, seen while `in_macro` is 0, enters macro-op mode. The micro-op issued first is the one at the current `upc`, which is 0. While `in_macro` is 1, `is_macro` is ignored.
- R10: During reset, `pc` takes `reset_vec`, `npc` takes `reset_vec`+4, `nnpc` takes `reset_vec`+8, `upc`/`nupc` become 0/1 and `in_macro` becomes 0.
- R11: When `fault` and `last_uop` are both high in one step, the fault behaviour of R4 applies and the PC chain does not advance.
- R12: With `step` low, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_vec | input | 32 | Start address loaded during reset |
| step | input | 1 | One retired step occurs this cycle |
| fault | input | 1 | The step raised a fault |
| need_more | input | 1 | The decoder needs another fetch word |
| is_macro | input | 1 | The decoded instruction is a macro-op |
| last_uop | input | 1 | The current micro-op is the final one |
| len_en | input | 1 | Use `inst_len` for the following PC |
| inst_len | input | 4 | Byte length of the decoded instruction |
| fetch_addr | output | 32 | Aligned instruction fetch address |
| pc | output | 32 | Current PC |
| npc | output | 32 | Following PC |
| nnpc | output | 32 | PC after the following one |
| upc | output | 8 | Current micro-op index |
| nupc | output | 8 | Next micro-op index |
| in_macro | output | 1 | A macro-op is being sequenced |

## Verification
The assertions assume that the qualifier flags are sampled only in cycles where `step` is high. They also assume that `inst_len` matters only together with `len_en`. The bench drives every flag at random, including combinations that a real decoder would never produce, such as `last_uop` outside a macro-op or `need_more` during a fault. Each combination's outcome is defined by the priority order the requirements give, so the stimulus stays within what the properties cover. Fetch offsets stay small because runs of `need_more` are short, so the 8-bit offset never wraps.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int ADDR_W   = 32;
    localparam int WORD_B   = 4;
    localparam int OFF_W    = 8;
    localparam int UPC_W    = 8;
    localparam int LEN_W    = 4;
    localparam int ALIGN_W  = $clog2(WORD_B);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [UPC_W-1:0]  upc_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef struct packed {
        addr_t pc;
        addr_t npc;
        addr_t nnpc;
        off_t  off;
        upc_t  upc;
        upc_t  nupc;
        logic  in_macro;
    } seq_state_t;
endpackage

// File: rtl/pcs_fetch_addr.sv
module pcs_fetch_addr
    import pcs_pkg::*;
(
    input  addr_t pc_q,
    input  off_t  off_q,
    output addr_t fetch_addr
);
    addr_t raw;
    always_comb begin
        raw = pc_q + addr_t'(off_q);
        fetch_addr = {raw[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end
endmodule

// File: rtl/pcs_step_ctrl.sv
module pcs_step_ctrl
    import pcs_pkg::*;
(
    input  logic step,
    input  logic fault,
    input  logic need_more,
    input  logic is_macro,
    input  logic last_uop,
    input  logic len_en,
    input  logic in_macro_q,
    output logic hold_fetch,
    output logic use_len,
    output logic adv_pc,
    output logic adv_uop,
    output logic clr_uop,
    output logic in_macro_d
);
    logic active, decode, macro_eff;
    always_comb begin
        active     = step & ~fault;
        hold_fetch = active & need_more & ~in_macro_q;
        decode     = active & ~in_macro_q & ~need_more;
        use_len    = decode & len_en;
        macro_eff  = in_macro_q | (decode & is_macro);
        clr_uop    = (step & fault) | (active & macro_eff & last_uop);
        adv_uop    = active & macro_eff & ~last_uop;
        adv_pc     = active & ~hold_fetch & ~adv_uop;
        if (!step)
            in_macro_d = in_macro_q;
        else if (clr_uop)
            in_macro_d = 1'b0;
        else if (hold_fetch)
            in_macro_d = in_macro_q;
        else
            in_macro_d = macro_eff;
    end
endmodule

// File: rtl/pcs_pc_chain.sv
module pcs_pc_chain
    import pcs_pkg::*;
(
    input  addr_t            pc_q,
    input  addr_t            npc_q,
    input  addr_t            nnpc_q,
    input  logic             use_len,
    input  logic [LEN_W-1:0] inst_len,
    input  logic             adv_pc,
    output addr_t            pc_d,
    output addr_t            npc_d,
    output addr_t            nnpc_d
);
    addr_t npc_w;
    always_comb begin
        npc_w  = use_len ? pc_q + addr_t'(inst_len) : npc_q;
        pc_d   = pc_q;
        npc_d  = npc_w;
        nnpc_d = nnpc_q;
        if (adv_pc) begin
            pc_d   = npc_w;
            npc_d  = nnpc_q;
            nnpc_d = nnpc_q + addr_t'(WORD_B);
        end
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      reset_vec,
    input  logic             step,
    input  logic             fault,
    input  logic             need_more,
    input  logic             is_macro,
    input  logic             last_uop,
    input  logic             len_en,
    input  logic [3:0]       inst_len,
    output logic [31:0]      fetch_addr,
    output logic [31:0]      pc,
    output logic [31:0]      npc,
    output logic [31:0]      nnpc,
    output logic [7:0]       upc,
    output logic [7:0]       nupc,
    output logic             in_macro
);
    seq_state_t st_q, st_d;
    logic hold_fetch, use_len, adv_pc, adv_uop, clr_uop, in_macro_d;
    addr_t pc_d, npc_d, nnpc_d;

    pcs_step_ctrl u_ctrl (
        .step(step), .fault(fault), .need_more(need_more),
        .is_macro(is_macro), .last_uop(last_uop), .len_en(len_en),
        .in_macro_q(st_q.in_macro), .hold_fetch(hold_fetch),
        .use_len(use_len), .adv_pc(adv_pc), .adv_uop(adv_uop),
        .clr_uop(clr_uop), .in_macro_d(in_macro_d)
    );

    pcs_pc_chain u_chain (
        .pc_q(st_q.pc), .npc_q(st_q.npc), .nnpc_q(st_q.nnpc),
        .use_len(use_len), .inst_len(inst_len), .adv_pc(adv_pc),
        .pc_d(pc_d), .npc_d(npc_d), .nnpc_d(nnpc_d)
    );

    pcs_fetch_addr u_fa (
        .pc_q(st_q.pc), .off_q(st_q.off), .fetch_addr(fetch_addr)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.pc       = reset_vec;
            st_d.npc      = reset_vec + addr_t'(WORD_B);
            st_d.nnpc     = reset_vec + addr_t'(2 * WORD_B);
            st_d.off      = '0;
            st_d.upc      = '0;
            st_d.nupc     = upc_t'(1);
            st_d.in_macro = 1'b0;
        end else if (step) begin
            st_d.pc       = pc_d;
            st_d.npc      = npc_d;
            st_d.nnpc     = nnpc_d;
            st_d.in_macro = in_macro_d;
            if (hold_fetch)
                st_d.off = st_q.off + off_t'(WORD_B);
            else
                st_d.off = '0;
            if (clr_uop) begin
                st_d.upc  = '0;
                st_d.nupc = upc_t'(1);
            end else if (adv_uop) begin
                st_d.upc  = st_q.nupc;
                st_d.nupc = st_q.nupc + upc_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc       = st_q.pc;
    assign npc      = st_q.npc;
    assign nnpc     = st_q.nnpc;
    assign upc      = st_q.upc;
    assign nupc     = st_q.nupc;
    assign in_macro = st_q.in_macro;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        step,
    input logic        fault,
    input logic        need_more,
    input logic        is_macro,
    input logic        last_uop,
    input logic        len_en,
    input logic [31:0] fetch_addr,
    input logic [31:0] pc,
    input logic [31:0] npc,
    input logic [31:0] nnpc,
    input logic [7:0]  upc,
    input logic [7:0]  nupc,
    input logic        in_macro
);
    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pc) && $stable(npc) && $stable(nnpc) && $stable(upc)
                  && $stable(nupc) && $stable(in_macro) && $stable(fetch_addr));

    assert_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step && fault |=> upc == 8'd0 && nupc == 8'd1 && !in_macro
                          && $stable(pc) && $stable(npc) && $stable(nnpc));

    assert_more_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step && !fault && need_more && !in_macro
        |=> $stable(pc) && fetch_addr == $past(fetch_addr) + 32'd4);

    assert_uop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step && !fault && in_macro && !last_uop
        |=> upc == $past(nupc) && nupc == $past(nupc) + 8'd1 && $stable(pc));

    assert_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step && !fault && in_macro && last_uop
        |=> !in_macro && upc == 8'd0 && pc == $past(npc));

    assert_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step && !fault && !in_macro && !need_more && !is_macro && !len_en
        |=> pc == $past(npc) && npc == $past(nnpc) && nnpc == $past(nnpc) + 32'd4);
endmodule

bind pc_sequencer pcs_checker u_chk (.*);

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] reset_vec = 32'h0000_1002;
    logic step = 0, fault = 0, need_more = 0, is_macro = 0, last_uop = 0, len_en = 0;
    logic [3:0] inst_len = 4'd0;
    logic [31:0] fetch_addr, pc, npc, nnpc;
    logic [7:0] upc, nupc;
    logic in_macro;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [31:0] m_pc, m_npc, m_nnpc;
    int m_off, m_upc, m_nupc;
    bit m_mac;
    string tag;

    always #2.5 clk = ~clk;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .reset_vec(reset_vec), .step(step),
        .fault(fault), .need_more(need_more), .is_macro(is_macro),
        .last_uop(last_uop), .len_en(len_en), .inst_len(inst_len),
        .fetch_addr(fetch_addr), .pc(pc), .npc(npc), .nnpc(nnpc),
        .upc(upc), .nupc(nupc), .in_macro(in_macro)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_all(string t);
        logic [31:0] fa;
        fa = (m_pc + 32'(m_off)) & 32'hFFFF_FFFC;
        chk({"R1 R3 fetch_addr ", t}, fetch_addr, fa);
        chk({t, " pc"}, pc, m_pc);
        chk({t, " npc"}, npc, m_npc);
        chk({t, " nnpc"}, nnpc, m_nnpc);
        chk({t, " upc"}, {24'd0, upc}, 32'(m_upc));
        chk({t, " nupc"}, {24'd0, nupc}, 32'(m_nupc));
        chk({t, " in_macro"}, {31'd0, in_macro}, {31'd0, m_mac});
    endtask

    task automatic model_reset();
        m_pc = reset_vec; m_npc = reset_vec + 4; m_nnpc = reset_vec + 8;
        m_off = 0; m_upc = 0; m_nupc = 1; m_mac = 0;
    endtask

    // behavioural update for one cycle with the currently driven inputs
    task automatic model_step();
        bit entering;
        if (!step) begin tag = "R12"; return; end
        if (fault) begin
            tag = last_uop ? "R11" : "R4";
            m_off = 0; m_upc = 0; m_nupc = 1; m_mac = 0;
            return;
        end
        if (!m_mac && need_more) begin
            tag = "R2"; m_off += 4; return;
        end
        m_off = 0;
        entering = 0;
        tag = "R7";
        if (!m_mac) begin
            if (len_en) begin m_npc = m_pc + 32'(inst_len); tag = "R8"; end
            if (is_macro) begin m_mac = 1; entering = 1; tag = "R9"; end
        end
        if (m_mac && last_uop) begin
            m_mac = 0; m_upc = 0; m_nupc = 1;
            if (!entering) tag = "R5";
        end
        if (m_mac) begin
            m_upc = m_nupc; m_nupc = (m_nupc + 1) % 256;
            if (!entering) tag = "R6";
        end else begin
            m_pc = m_npc; m_npc = m_nnpc; m_nnpc = m_nnpc + 4;
        end
    endtask

    task automatic drive(bit s, bit f, bit nm, bit im, bit lu, bit le, int ln);
        step = s; fault = f; need_more = nm; is_macro = im;
        last_uop = lu; len_en = le; inst_len = 4'(ln);
        model_step();
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R10 reset");
        // plain sequential advance
        drive(1,0,0,0,0,0,0);
        drive(0,1,1,1,1,1,7);            // R12 idle with noise
        // need more twice, then complete with variable length
        drive(1,0,1,0,0,0,0);
        drive(1,0,1,0,0,0,0);
        drive(1,0,0,0,0,1,5);            // R8
        // macro-op of three micro-ops
        drive(1,0,0,1,0,0,0);            // R9
        drive(1,0,1,1,0,0,0);            // R6, need_more ignored
        drive(1,0,0,0,1,0,0);            // R5
        // macro-op interrupted by fault together with last
        drive(1,0,0,1,0,0,0);
        drive(1,1,0,0,1,0,0);            // R11
        drive(1,1,1,0,0,0,0);            // R4 with pending offset clear
        // single micro-op macro
        drive(1,0,0,1,1,0,0);
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 100;
            drive(r < 80, ($urandom % 100) < 6, ($urandom % 100) < 20,
                  ($urandom % 100) < 15, ($urandom % 100) < 30,
                  ($urandom % 100) < 30, $urandom % 16);
            if (m_off > 40) drive(1,0,0,0,0,0,0);
        end
        // reset mid-run with new vector
        reset_vec = 32'h8000_0010;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        compare_all("R10 rerun");
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule